// File: doc/BRIEF.md
# Banked Memory Map Remap Controller

This block turns a 32-bit CPU address into a resource selection: main RAM with a 32 KB page number, one of three ROMs with a byte offset into that ROM, or no resource at all. The decode is purely combinational. It depends only on the address and on three pieces of state that the system writes through byte-wide I/O ports.

The first piece of state is a window register. It moves a four-page RAM window that sits just below the display area. The second is a switch that lays a small ROM over the top 32 KB of the first megabyte. The third is a mode bit that replaces the option-ROM and BIOS areas with RAM.

Everything in the first megabyte that the map defines is also visible in a mirror at 0xFFF00000. Firmware fetched near the top of the 4 GB space therefore sees the same picture. The memories themselves and the bus timing lie outside this block.

Top module: `mmr_remap`

## Requirements
- R1: After reset, the window register holds 0x08, the overlay ROM is selected and RAM-shadow mode is off. An I/O read of port 0x0461 returns the window register, and any other read returns 0x00.
- R2: Addresses 0x00000–0x7FFFF and 0x100000–0xFFFFFF select RAM (target code 1), with page = address bits [23:15].
- R3: Addresses 0x80000–0x9FFFF select RAM with page = {window[7:1], address[16:15]}, which equals ((window & 0xFE) << 1) + slot.
- R4: A write to port 0x0461 replaces the window register only when bits [7:1] of the data differ from the register. Otherwise the whole register, bit 0 included, keeps its value.
- R5: Writing 0x00 or 0x10 to port 0x043D selects the overlay ROM. Writing 0x02 or 0x12 deselects it, and every other value leaves it unchanged. While it is selected, 0xF8000–0xFFFFF selects the overlay ROM (code 3) with offset = address − 0xF8000.
- R6: 0xE8000–0xF7FFF selects RAM in shadow mode and otherwise the 96 KB BIOS ROM (code 2) with offset = address − 0xE8000. The same rule applies to 0xF8000–0xFFFFF while the overlay ROM is deselected.
- R7: A write to port 0x053D sets shadow mode from data bit 1. In shadow mode, 0xC0000–0xDFFFF selects RAM.
- R8: Outside shadow mode, 0xD8000–0xD9FFF selects the 8 KB IDE ROM (code 4) with offset = address − 0xD8000, and 0xC0000–0xD7FFF and 0xDA000–0xDFFFF select nothing (code 0).
- R9: 0xA0000–0xBFFFF, 0xE0000–0xE7FFF and every address from 0x1000000 up to 0xFFEFFFFF select nothing. When the target is not RAM, the page output is 0, and when the target is not a ROM, the offset output is 0.
- R10: An address 0xFFF00000 + x, with x below 0x100000, decodes exactly as x does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the state registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, sampled on the clock edge |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (window register on port 0x0461) |
| cpu_addr | input | 32 | CPU physical address to decode |
| sel_target | output | 3 | 0 none, 1 RAM, 2 BIOS ROM, 3 overlay ROM, 4 IDE ROM |
| sel_page | output | 9 | RAM page number when the target is RAM |
| sel_offset | output | 17 | Byte offset into the selected ROM |

## Verification
The decode is probed with a fixed set of addresses at every region edge, and each probe is sent both plain and mirrored. The probes are repeated after each combination of overlay and shadow state, so that overlay priority and shadow-mode precedence can be told apart. Window writes are tried with a value that changes only bit 0, with values that change the upper bits, and with the extremes 0x00 and 0xFF, which separates the bit-0 hold rule from a plain load. Port 0x043D gets both accepted value pairs and values one bit away from them, such as 0x01, 0x03 and 0x11. These show that unlisted codes leave the overlay unchanged.

// File: rtl/mmr_pkg.sv
package mmr_pkg;

  localparam int IO_AW  = 16;
  localparam int IO_DW  = 8;
  localparam int PAGE_W = 9;
  localparam int OFF_W  = 17;
  localparam int LOW_W  = 20;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_RAM  = 3'd1,
    TGT_BIOS = 3'd2,
    TGT_ITF  = 3'd3,
    TGT_IDE  = 3'd4
  } tgt_e;

  localparam logic [IO_AW-1:0] PORT_ROMSEL = 16'h043D;
  localparam logic [IO_AW-1:0] PORT_WIN    = 16'h0461;
  localparam logic [IO_AW-1:0] PORT_SHADOW = 16'h053D;
  localparam logic [IO_DW-1:0] WIN_RESET   = 8'h08;

  localparam logic [LOW_W-1:0] WIN_LO   = 20'h80000;
  localparam logic [LOW_W-1:0] HOLE_LO  = 20'hA0000;
  localparam logic [LOW_W-1:0] OPT_LO   = 20'hC0000;
  localparam logic [LOW_W-1:0] IDE_LO   = 20'hD8000;
  localparam logic [LOW_W-1:0] IDE_HI   = 20'hDA000;
  localparam logic [LOW_W-1:0] OPT_HI   = 20'hE0000;
  localparam logic [LOW_W-1:0] BIOS_LO  = 20'hE8000;
  localparam logic [LOW_W-1:0] ITF_LO   = 20'hF8000;

  // Window page: slot number appended to window bits [7:1].
  function automatic logic [PAGE_W-1:0] win_page(input logic [IO_DW-1:0] w,
                                                 input logic [1:0] slot);
    return {w[IO_DW-1:1], slot};
  endfunction

  // Byte offset of a low address from a ROM base.
  function automatic logic [OFF_W-1:0] rom_offset(input logic [LOW_W-1:0] a,
                                                  input logic [LOW_W-1:0] base);
    logic [LOW_W-1:0] d;
    d = a - base;
    return d[OFF_W-1:0];
  endfunction

  // Overlay command: {valid, select}.
  function automatic logic [1:0] itf_cmd(input logic [IO_DW-1:0] d);
    case (d)
      8'h00, 8'h10: return 2'b11;
      8'h02, 8'h12: return 2'b10;
      default:      return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/mmr_regs.sv
module mmr_regs
  import mmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [IO_DW-1:0] io_wdata,
  output logic [IO_DW-1:0] io_rdata,
  output logic [IO_DW-1:0] win_q,
  output logic             itf_q,
  output logic             shadow_q
);

  logic       wr_win, wr_romsel, wr_shadow;
  logic       win_upd;
  logic [1:0] itf_c;
  logic       itf_set, itf_clr;

  assign wr_win    = io_wr && (io_addr == PORT_WIN);
  assign wr_romsel = io_wr && (io_addr == PORT_ROMSEL);
  assign wr_shadow = io_wr && (io_addr == PORT_SHADOW);

  assign win_upd = wr_win && (io_wdata[IO_DW-1:1] != win_q[IO_DW-1:1]);
  assign itf_c   = itf_cmd(io_wdata);
  assign itf_set = wr_romsel && itf_c[1] && itf_c[0];
  assign itf_clr = wr_romsel && itf_c[1] && !itf_c[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q    <= WIN_RESET;
      itf_q    <= 1'b1;
      shadow_q <= 1'b0;
    end else begin
      if (win_upd)   win_q    <= io_wdata;
      if (itf_set)   itf_q    <= 1'b1;
      if (itf_clr)   itf_q    <= 1'b0;
      if (wr_shadow) shadow_q <= io_wdata[1];
    end
  end

  assign io_rdata = (io_rd && (io_addr == PORT_WIN)) ? win_q : '0;

  // R4: upper bits equal -> register unchanged
  a_r4_win_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_win && (io_wdata[IO_DW-1:1] == win_q[IO_DW-1:1])) |=> $stable(win_q));

  // R4: upper bits differ -> full byte loaded
  a_r4_win_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_win && (io_wdata[IO_DW-1:1] != win_q[IO_DW-1:1])) |=> (win_q == $past(io_wdata)));

  // R5: unlisted codes leave the overlay alone
  a_r5_itf_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_romsel && !itf_set && !itf_clr) |=> $stable(itf_q));

  // R7: shadow mode follows data bit 1
  a_r7_shadow_bit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_shadow |=> (shadow_q == $past(io_wdata[1])));

endmodule

// File: rtl/mmr_fold.sv
module mmr_fold
  import mmr_pkg::*;
#(
  parameter int              ADDR_W      = 32,
  parameter bit              MIRROR_EN   = 1'b1,
  parameter logic [ADDR_W-1:0] EXT_LIMIT = 32'h0100_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [LOW_W-1:0]  low_addr,
  output logic              low_hit,
  output logic              ext_hit
);

  localparam int TOP_W = ADDR_W - LOW_W;

  logic plain_low;
  logic mirror_low;

  assign plain_low = (addr[ADDR_W-1:LOW_W] == '0);
  assign low_addr  = addr[LOW_W-1:0];

  generate
    if (MIRROR_EN) begin : g_mirror
      assign mirror_low = (addr[ADDR_W-1:LOW_W] == {TOP_W{1'b1}});
    end else begin : g_nomirror
      assign mirror_low = 1'b0;
    end
  endgenerate

  assign low_hit = plain_low || mirror_low;
  assign ext_hit = !plain_low && (addr < EXT_LIMIT);

endmodule

// File: rtl/mmr_decode.sv
module mmr_decode
  import mmr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LOW_W-1:0]  low_addr,
  input  logic              low_hit,
  input  logic              ext_hit,
  input  logic [IO_DW-1:0]  win_q,
  input  logic              itf_q,
  input  logic              shadow_q,
  output tgt_e              target,
  output logic [PAGE_W-1:0] page,
  output logic [OFF_W-1:0]  offset
);

  localparam int LOW_PG_W = LOW_W - 15;

  // Region hits in the first megabyte
  logic in_base, in_win, in_opt, in_ide, in_bios_lo, in_itf;

  assign in_base    = low_hit && (low_addr < WIN_LO);
  assign in_win     = low_hit && (low_addr >= WIN_LO)  && (low_addr < HOLE_LO);
  assign in_opt     = low_hit && (low_addr >= OPT_LO)  && (low_addr < OPT_HI);
  assign in_ide     = in_opt  && (low_addr >= IDE_LO)  && (low_addr < IDE_HI);
  assign in_bios_lo = low_hit && (low_addr >= BIOS_LO) && (low_addr < ITF_LO);
  assign in_itf     = low_hit && (low_addr >= ITF_LO);

  // Resource events, brought out for the checks
  logic sel_ram, sel_bios, sel_itf, sel_ide;

  assign sel_itf  = in_itf && itf_q;
  assign sel_ide  = in_ide && !shadow_q;
  assign sel_bios = !shadow_q && (in_bios_lo || (in_itf && !itf_q));
  assign sel_ram  = ext_hit || in_base || in_win ||
                    (shadow_q && (in_opt || in_bios_lo || (in_itf && !itf_q)));

  always_comb begin
    target = TGT_NONE;
    page   = '0;
    offset = '0;
    if (sel_itf) begin
      target = TGT_ITF;
      offset = rom_offset(low_addr, ITF_LO);
    end else if (sel_ide) begin
      target = TGT_IDE;
      offset = rom_offset(low_addr, IDE_LO);
    end else if (sel_bios) begin
      target = TGT_BIOS;
      offset = rom_offset(low_addr, BIOS_LO);
    end else if (sel_ram) begin
      target = TGT_RAM;
      if (ext_hit)
        page = addr[15+PAGE_W-1:15];
      else if (in_win)
        page = win_page(win_q, low_addr[16:15]);
      else
        page = {{(PAGE_W-LOW_PG_W){1'b0}}, low_addr[LOW_W-1:15]};
    end
  end

  a_r9_onehot_resource: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_ram, sel_bios, sel_itf, sel_ide}));

  a_r5_itf_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (itf_q && low_hit && (low_addr >= ITF_LO)) |-> (target == TGT_ITF));

  a_r7_shadow_opt_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_q && in_opt) |-> (target == TGT_RAM));

  a_r3_window_slot: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |-> (page[1:0] == low_addr[16:15] && page[PAGE_W-1:2] == win_q[IO_DW-1:1]));

  a_r9_hole_none: assert property (@(posedge clk) disable iff (!rst_n)
    (low_hit && low_addr >= HOLE_LO && low_addr < OPT_LO) |-> (target == TGT_NONE));

endmodule

// File: rtl/mmr_remap.sv
module mmr_remap
  import mmr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter bit MIRROR_EN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 io_wr,
  input  logic                 io_rd,
  input  logic [IO_AW-1:0]     io_addr,
  input  logic [IO_DW-1:0]     io_wdata,
  output logic [IO_DW-1:0]     io_rdata,
  input  logic [ADDR_W-1:0]    cpu_addr,
  output logic [2:0]           sel_target,
  output logic [PAGE_W-1:0]    sel_page,
  output logic [OFF_W-1:0]     sel_offset
);

  logic [IO_DW-1:0] win_q;
  logic             itf_q, shadow_q;
  logic [LOW_W-1:0] low_addr;
  logic             low_hit, ext_hit;
  tgt_e             target;

  mmr_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .win_q    (win_q),
    .itf_q    (itf_q),
    .shadow_q (shadow_q)
  );

  mmr_fold #(.ADDR_W(ADDR_W), .MIRROR_EN(MIRROR_EN)) u_fold (
    .addr     (cpu_addr),
    .low_addr (low_addr),
    .low_hit  (low_hit),
    .ext_hit  (ext_hit)
  );

  mmr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (cpu_addr),
    .low_addr (low_addr),
    .low_hit  (low_hit),
    .ext_hit  (ext_hit),
    .win_q    (win_q),
    .itf_q    (itf_q),
    .shadow_q (shadow_q),
    .target   (target),
    .page     (sel_page),
    .offset   (sel_offset)
  );

  assign sel_target = target;

  // R9: non-RAM results carry no page
  a_r9_page_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_target != TGT_RAM) |-> (sel_page == '0));

  // R9: non-ROM results carry no offset
  a_r9_offset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_target == TGT_RAM || sel_target == TGT_NONE) |-> (sel_offset == '0));

endmodule

// File: tb/test_mmr_remap.sv
module test_mmr_remap;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [31:0] cpu_addr = '0;
  logic [2:0]  sel_target;
  logic [8:0]  sel_page;
  logic [16:0] sel_offset;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference state
  int m_win, m_itf, m_shadow;

  always #(CLK_P/2) clk = ~clk;

  mmr_remap i_mmr_remap (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .cpu_addr(cpu_addr), .sel_target(sel_target),
    .sel_page(sel_page), .sel_offset(sel_offset)
  );

  // Behavioural expectation, from the requirement text
  task automatic expect_map(input longint a, output int t, output int pg, output int off);
    longint x;
    t = 0; pg = 0; off = 0;
    if (a >= 64'hFFF00000)      x = a - 64'hFFF00000;        // R10
    else if (a < 64'h100000)    x = a;
    else begin
      x = -1;
      if (a < 64'h1000000) begin t = 1; pg = int'(a / 32768); end   // R2
    end
    if (x < 0) return;
    if (x < 64'h80000) begin t = 1; pg = int'(x / 32768); end
    else if (x < 64'hA0000) begin
      t = 1; pg = (m_win & 'hFE) * 2 + int'((x - 64'h80000) / 32768);
    end
    else if (x < 64'hC0000) t = 0;
    else if (x < 64'hE0000) begin
      if (m_shadow != 0) begin t = 1; pg = int'(x / 32768); end
      else if (x >= 64'hD8000 && x < 64'hDA000) begin t = 4; off = int'(x - 64'hD8000); end
    end
    else if (x < 64'hE8000) t = 0;
    else if (x >= 64'hF8000 && m_itf != 0) begin t = 3; off = int'(x - 64'hF8000); end
    else if (m_shadow != 0) begin t = 1; pg = int'(x / 32768); end
    else begin t = 2; off = int'(x - 64'hE8000); end
  endtask

  function automatic string tag_of(input longint a);
    longint x;
    if (a >= 64'hFFF00000) return "R10";
    if (a >= 64'h100000) return (a < 64'h1000000) ? "R2" : "R9";
    x = a;
    if (x < 64'h80000) return "R2";
    if (x < 64'hA0000) return "R3";
    if (x < 64'hC0000) return "R9";
    if (x < 64'hE0000) return (m_shadow != 0) ? "R7" : "R8";
    if (x < 64'hE8000) return "R9";
    if (x >= 64'hF8000 && m_itf != 0) return "R5";
    return "R6";
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s addr=%h actual=%h expected=%h", tag, what, cpu_addr, act, exp);
    end
  endtask

  // One clock: drive at negedge, compare before the edge, advance model at the edge
  task automatic cyc(input bit wr, input bit rd, input logic [15:0] pa,
                     input logic [7:0] pd, input logic [31:0] a, input string rtag);
    int t, pg, off;
    @(negedge clk);
    io_wr = wr; io_rd = rd; io_addr = pa; io_wdata = pd; cpu_addr = a;
    #(CLK_P/4);
    if (rst_n) begin
      expect_map({32'h0, a}, t, pg, off);
      check(tag_of({32'h0, a}), "target", int'(sel_target), t);
      check(tag_of({32'h0, a}), "page",   int'(sel_page), pg);
      check(tag_of({32'h0, a}), "offset", int'(sel_offset), off);
      check(rtag, "rdata", int'(io_rdata), (rd && pa == 16'h0461) ? m_win : 0);
    end
    @(posedge clk);
    if (!rst_n) begin
      m_win = 'h08; m_itf = 1; m_shadow = 0;
    end else if (wr) begin
      if (pa == 16'h0461 && ((int'(pd) & 'hFE) != (m_win & 'hFE))) m_win = int'(pd);
      if (pa == 16'h043D) begin
        if (pd == 8'h00 || pd == 8'h10) m_itf = 1;
        if (pd == 8'h02 || pd == 8'h12) m_itf = 0;
      end
      if (pa == 16'h053D) m_shadow = int'(pd[1]);
    end
  endtask

  task automatic io_write(input logic [15:0] pa, input logic [7:0] pd, input string rtag);
    cyc(1'b1, 1'b0, pa, pd, 32'h0009_8000, rtag);
  endtask

  task automatic read_win(input string rtag);
    cyc(1'b0, 1'b1, 16'h0461, 8'h00, 32'h0008_8000, rtag);
  endtask

  localparam int NPROBE = 26;
  function automatic logic [31:0] probe_addr(input int i);
    case (i)
      0:  return 32'h0000_0000;  1:  return 32'h0007_FFFF;
      2:  return 32'h0008_0000;  3:  return 32'h0008_9ABC;
      4:  return 32'h0009_0001;  5:  return 32'h0009_FFFF;
      6:  return 32'h000A_0000;  7:  return 32'h000B_FFFF;
      8:  return 32'h000C_0000;  9:  return 32'h000D_7FFF;
      10: return 32'h000D_8000;  11: return 32'h000D_9FFF;
      12: return 32'h000D_A000;  13: return 32'h000D_FFFF;
      14: return 32'h000E_0000;  15: return 32'h000E_7FFF;
      16: return 32'h000E_8000;  17: return 32'h000F_7FFF;
      18: return 32'h000F_8000;  19: return 32'h000F_FFFF;
      20: return 32'h0010_0000;  21: return 32'h00FF_FFFF;
      22: return 32'h0100_0000;  23: return 32'hFFEF_FFFF;
      24: return 32'h0054_3210;  default: return 32'h8000_0000;
    endcase
  endfunction

  task automatic sweep();
    for (int i = 0; i < NPROBE; i++) begin
      logic [31:0] a;
      a = probe_addr(i);
      cyc(1'b0, 1'b0, 16'h0000, 8'h00, a, "R9");
      if (a < 32'h0010_0000)
        cyc(1'b0, 1'b0, 16'h0000, 8'h00, a | 32'hFFF0_0000, "R10");
    end
  endtask

  initial begin
    m_win = 'h08; m_itf = 1; m_shadow = 0;
    #1 rst_n = 1'b0;
    repeat (3) cyc(1'b0, 1'b0, 16'h0, 8'h0, 32'h0, "R1");
    rst_n = 1'b1;
    // R1: reset state
    read_win("R1");
    sweep();
    // R4: bit-0-only change is held, upper change loads
    io_write(16'h0461, 8'h09, "R4"); read_win("R4");
    io_write(16'h0461, 8'h0B, "R4"); read_win("R4");
    io_write(16'h0461, 8'h0A, "R4"); read_win("R4");
    io_write(16'h0461, 8'hFF, "R4"); read_win("R4"); sweep();
    io_write(16'h0461, 8'h00, "R4"); read_win("R4"); sweep();
    io_write(16'h0461, 8'h01, "R4"); read_win("R4");
    cyc(1'b0, 1'b1, 16'h0460, 8'h00, 32'h0, "R1");
    // R5: unlisted codes ignored, then deselect
    io_write(16'h043D, 8'h01, "R5"); sweep();
    io_write(16'h043D, 8'h03, "R5"); io_write(16'h043D, 8'h11, "R5");
    io_write(16'h043D, 8'h02, "R5"); sweep();     // R6 BIOS at top
    io_write(16'h043D, 8'h13, "R5"); sweep();
    // R7: shadow on with overlay off
    io_write(16'h053D, 8'hFF, "R7"); sweep();
    io_write(16'h043D, 8'h10, "R5"); sweep();     // overlay over shadow RAM
    io_write(16'h053D, 8'hFD, "R8"); sweep();     // R8: bit1 clear
    io_write(16'h043D, 8'h12, "R5");
    io_write(16'h053D, 8'h02, "R7");
    io_write(16'h053D, 8'h00, "R8"); sweep();
    io_write(16'h0461, 8'h5C, "R3"); sweep();
    // reset again restores defaults
    rst_n = 1'b0;
    cyc(1'b0, 1'b0, 16'h0, 8'h0, 32'h0, "R1");
    rst_n = 1'b1;
    read_win("R1"); sweep();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule